// File: doc/BRIEF.md
# Reset distribution and protection controller

This block gathers the system's reset sources into two classes and drives the reset and protection controls of the board. A power-up input and a manual push-button input form the hardware class. Software forms the second class by writing a command bit. The block drives:

- a host CPU reset;
- a DSP reset;
- a DRAM error-report mask;
- a DRAM parity-mode select;
- NVRAM and flash write-protect enables;
- one mask per interrupt level;
- a board program register clear;
- a time-out status mask.

The host CPU reset follows the hardware class only. Every other control except the board program register clear is retained. Either class sets it, and it stays set after the reset ends until software releases it. Software releases it by writing a 1 to its bit in a write-only control word. The time-out status mask belongs to the hardware class alone.

The hardware inputs are active low and asynchronous. A synchronizer brings them into the clock domain, and the reset is then stretched and released synchronously. A software command produces an internal pulse of fixed length. While any reset is active, writes to the control word are ignored.

Top module: `rst_guard_ctrl`

## Requirements
- R1: Driving either `por_n` or `btn_n` low starts a hardware reset. While it lasts, `cpu_rst_n` and `dsp_rst_n` are 0. `dram_err_mask`, `parity_even`, `nvram_wp`, `flash_wp`, `tmo_mask`, every `irq_mask` bit and `bpr_clr` are all 1.
- R2: `cpu_rst_n` goes low as soon as either hardware input is low. With default parameters it rises on the 18th rising clock edge after both inputs are high (2 synchronizer stages plus 16 stretch cycles). A software reset never drives it low.
- R3: `dram_err_mask` is set by both reset classes and stays 1 after the reset. Writing control bit 1 clears it.
- R4: `parity_even` (1 = even parity) is forced to 1 by both reset classes and stays 1 after the reset. Writing control bit 2 clears it, which selects odd parity.
- R5: `nvram_wp` and `flash_wp` are set by both reset classes and stay 1 after the reset. Writing control bit 3 clears `nvram_wp`, and writing control bit 4 clears `flash_wp`.
- R6: `irq_mask[k]` masks interrupt level k+1. Both reset classes set all bits. Writing control bit 6+k clears bit k alone.
- R7: `dsp_rst_n` is driven low by both reset classes and stays low after the reset. Writing control bit 0 releases it. `bpr_clr` is 1 exactly while a hardware reset or a software reset pulse is active.
- R8: Writing control bit 13 while no reset is active starts a software reset. It sets every retained control at that clock edge. It also holds `bpr_clr` at 1 for exactly 16 cycles, starting in the cycle after the write edge.
- R9: `tmo_mask` is set only by a hardware reset and stays 1 afterwards. A software reset leaves it unchanged. Writing control bit 5 clears it.
- R10: A write is ignored while a hardware reset or a software pulse is active. The release bits that share a word with the software reset command (bit 13) are also ignored.
- R11: A 0 in a control bit has no effect on the matching control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-up reset, active low |
| btn_n | input | 1 | Asynchronous push-button reset, active low |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 14 | Control word: release bits 0..12, software reset command bit 13 |
| cpu_rst_n | output | 1 | Host CPU reset, active low |
| dsp_rst_n | output | 1 | DSP reset, active low, retained |
| dram_err_mask | output | 1 | DRAM error-report mask |
| parity_even | output | 1 | DRAM parity select, 1 = even |
| nvram_wp | output | 1 | NVRAM write protect |
| flash_wp | output | 1 | Flash write protect |
| irq_mask | output | 7 | Interrupt level masks, bit k = level k+1 |
| bpr_clr | output | 1 | Board program register clear |
| tmo_mask | output | 1 | Time-out status mask |

## Verification
Two pairs of events can land in the same cycle.

The first pair is a release write and a reset. The bench provokes it by placing release bits in the same word as the software reset command. It also writes release words while the software pulse is running. It judges the result by showing that every retained control is still set once the pulse ends.

The second pair is a hardware reset and a running software pulse. The bench presses the button in the middle of the pulse. It expects `cpu_rst_n` to fall at once, `tmo_mask` to be set, and the full reset state to be present after the stretch.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
   // release bit positions inside the control word
   localparam int unsigned BIT_DSP  = 0;
   localparam int unsigned BIT_DRAM = 1;
   localparam int unsigned BIT_PAR  = 2;
   localparam int unsigned BIT_NVR  = 3;
   localparam int unsigned BIT_FLS  = 4;
   localparam int unsigned BIT_TMO  = 5;
   localparam int unsigned IRQ_BASE = 6;

   function automatic int unsigned rel_bits(int unsigned levels);
      return IRQ_BASE + levels;
   endfunction
endpackage

// File: rtl/rgc_hw_sync.sv
module rgc_hw_sync #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned STRETCH     = 16
) (
   input  logic clk,
   input  logic arst_n,
   output logic hw_active
);
   logic [SYNC_STAGES-1:0] chain;
   logic                   sync_n;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[SYNC_STAGES-2:0], 1'b1};
   end
   assign sync_n = chain[SYNC_STAGES-1];

   generate
      if (STRETCH == 0) begin : g_nostretch
         assign hw_active = !sync_n;
      end else begin : g_stretch
         localparam int unsigned CW = $clog2(STRETCH + 1);
         localparam logic [CW-1:0] LOADV = CW'(STRETCH);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n)         cnt <= LOADV;
            else if (!sync_n)    cnt <= LOADV;
            else if (cnt != '0)  cnt <= cnt - 1'b1;
         end
         assign hw_active = !sync_n || (cnt != '0);

         AST_HW_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
            !sync_n |=> hw_active); // R2
      end
   endgenerate
endmodule

// File: rtl/rgc_sw_pulse.sv
module rgc_sw_pulse #(
   parameter int unsigned LEN = 16
) (
   input  logic clk,
   input  logic arst_n,
   input  logic start,
   output logic active
);
   localparam int unsigned CW = $clog2(LEN + 1);
   localparam logic [CW-1:0] LOADV = CW'(LEN);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                cnt <= '0;
      else if (start && !active)  cnt <= LOADV;
      else if (cnt != '0)         cnt <= cnt - 1'b1;
   end
   assign active = (cnt != '0);

   AST_SW_START: assert property (@(posedge clk) disable iff (!arst_n)
      (start && !active) |=> active); // R8
endmodule

// File: rtl/rgc_hold.sv
module rgc_hold (
   input  logic clk,
   input  logic arst_n,
   input  logic set,
   input  logic rel,
   output logic q
);
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)  q <= 1'b1;
      else if (set) q <= 1'b1;
      else if (rel) q <= 1'b0;
   end

   AST_HOLD_SET: assert property (@(posedge clk) disable iff (!arst_n)
      set |=> q); // R3
   AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!arst_n)
      (!set && !rel) |=> $stable(q)); // R11
endmodule

// File: rtl/rst_guard_ctrl.sv
module rst_guard_ctrl #(
   parameter int unsigned IRQ_LEVELS  = 7,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HW_STRETCH  = 16,
   parameter int unsigned SW_PULSE    = 16,
   localparam int unsigned NREL       = rgc_pkg::rel_bits(IRQ_LEVELS),
   localparam int unsigned CTRL_W     = NREL + 1
) (
   input  logic                  clk,
   input  logic                  por_n,
   input  logic                  btn_n,
   input  logic                  wr_en,
   input  logic [CTRL_W-1:0]     wr_data,
   output logic                  cpu_rst_n,
   output logic                  dsp_rst_n,
   output logic                  dram_err_mask,
   output logic                  parity_even,
   output logic                  nvram_wp,
   output logic                  flash_wp,
   output logic [IRQ_LEVELS-1:0] irq_mask,
   output logic                  bpr_clr,
   output logic                  tmo_mask
);
   import rgc_pkg::*;

   localparam int unsigned SWR = NREL;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (IRQ_LEVELS < 1 || IRQ_LEVELS > 15) begin : g_bad_irq
         $error("IRQ_LEVELS must be 1..15");
      end
      if (SW_PULSE < 1) begin : g_bad_pulse
         $error("SW_PULSE must be at least 1");
      end
   endgenerate

   logic            raw_n;
   logic            hw_rst;
   logic            sw_active;
   logic            busy;
   logic            wr_ok;
   logic            sw_cmd;
   logic            set_all;
   logic [NREL-1:0] rel_vec;
   logic [NREL-1:0] held;

   assign raw_n = por_n & btn_n;

   rgc_hw_sync #(.SYNC_STAGES(SYNC_STAGES), .STRETCH(HW_STRETCH)) u_hw (
      .clk       (clk),
      .arst_n    (raw_n),
      .hw_active (hw_rst)
   );

   assign busy    = hw_rst | sw_active;
   assign wr_ok   = wr_en & ~busy;
   assign sw_cmd  = wr_ok & wr_data[SWR];
   assign rel_vec = (wr_ok && !wr_data[SWR]) ? wr_data[NREL-1:0] : '0;
   assign set_all = hw_rst | sw_active | sw_cmd;

   rgc_sw_pulse #(.LEN(SW_PULSE)) u_sw (
      .clk    (clk),
      .arst_n (raw_n),
      .start  (sw_cmd),
      .active (sw_active)
   );

   generate
      for (genvar i = 0; i < NREL; i++) begin : g_hold
         if (i == BIT_TMO) begin : g_hwonly
            rgc_hold u_h (.clk(clk), .arst_n(raw_n), .set(hw_rst),
                          .rel(rel_vec[i]), .q(held[i]));
         end else begin : g_both
            rgc_hold u_h (.clk(clk), .arst_n(raw_n), .set(set_all),
                          .rel(rel_vec[i]), .q(held[i]));
         end
      end
   endgenerate

   assign cpu_rst_n     = ~hw_rst;
   assign bpr_clr       = busy;
   assign dsp_rst_n     = ~held[BIT_DSP];
   assign dram_err_mask = held[BIT_DRAM];
   assign parity_even   = held[BIT_PAR];
   assign nvram_wp      = held[BIT_NVR];
   assign flash_wp      = held[BIT_FLS];
   assign tmo_mask      = held[BIT_TMO];
   assign irq_mask      = held[IRQ_BASE +: IRQ_LEVELS];

   AST_TMO_SW_KEEP: assert property (@(posedge clk) disable iff (!raw_n)
      (sw_active && !hw_rst) |=> $stable(tmo_mask)); // R9
   AST_NO_RELEASE_BUSY: assert property (@(posedge clk) disable iff (!raw_n)
      busy |=> ((held | $past(held)) == held)); // R10
   AST_SW_CPU_UP: assert property (@(posedge clk) disable iff (!raw_n)
      (sw_active && !hw_rst) |-> cpu_rst_n); // R2
endmodule

// File: tb/test_rst_guard_ctrl.sv
`timescale 1ns/1ps
module test_rst_guard_ctrl;
   logic        clk = 1'b0;
   logic        por_n, btn_n, wr_en;
   logic [13:0] wr_data;
   logic        cpu_rst_n, dsp_rst_n, dram_err_mask, parity_even;
   logic        nvram_wp, flash_wp, bpr_clr, tmo_mask;
   logic [6:0]  irq_mask;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   localparam logic [12:0] ALL  = 13'h1FFF;
   localparam logic [12:0] SWST = 13'h1FDF;

   always #5 clk = ~clk;

   rst_guard_ctrl i_rst_guard_ctrl (
      .clk(clk), .por_n(por_n), .btn_n(btn_n), .wr_en(wr_en), .wr_data(wr_data),
      .cpu_rst_n(cpu_rst_n), .dsp_rst_n(dsp_rst_n), .dram_err_mask(dram_err_mask),
      .parity_even(parity_even), .nvram_wp(nvram_wp), .flash_wp(flash_wp),
      .irq_mask(irq_mask), .bpr_clr(bpr_clr), .tmo_mask(tmo_mask)
   );

   function automatic logic [12:0] state();
      return {irq_mask, tmo_mask, flash_wp, nvram_wp, parity_even,
              dram_err_mask, ~dsp_rst_n};
   endfunction

   task automatic check(string req, logic [31:0] a, logic [31:0] e);
      checks++;
      if (a !== e) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, a, e);
      end
   endtask

   task automatic wr(logic [13:0] d);
      wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic press_button();
      btn_n = 1'b0;
      repeat (3) @(negedge clk);
      btn_n = 1'b1;
      for (int k = 0; k < 40 && !cpu_rst_n; k++) @(negedge clk);
      @(negedge clk);
   endtask

   // software reset with release bits in the command word and during the pulse
   task automatic sw_reset(output int hi, output int cpu_lo);
      wr_data = 14'h3FFF; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      hi = 0; cpu_lo = 0;
      for (int j = 0; j < 40; j++) begin
         if (j == 3) begin wr_en = 1'b1; wr_data = 14'h1FFF; end
         if (j == 5) wr_en = 1'b0;
         if (bpr_clr) hi++;
         if (!cpu_rst_n) cpu_lo++;
         @(negedge clk);
      end
      wr_data = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [12:0] exp;
      logic [12:0] lfsr;
      int cnt, hi, lo;
      string tag;

      por_n = 1'b0; btn_n = 1'b1; wr_en = 1'b0; wr_data = '0;
      repeat (3) @(negedge clk);
      check("R1 cpu_rst_n in power-up", {31'd0, cpu_rst_n}, 32'd0);
      check("R1 state in power-up", {19'd0, state()}, {19'd0, ALL});
      check("R7 bpr_clr in power-up", {31'd0, bpr_clr}, 32'd1);
      wr(14'h1FFF);   // R10: ignored during hardware reset
      check("R10 write in hw reset", {19'd0, state()}, {19'd0, ALL});

      por_n = 1'b1;
      cnt = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (!cpu_rst_n) cnt++;
      end
      check("R2 release latency", cnt, 17);
      check("R1 retained after power-up", {19'd0, state()}, {19'd0, ALL});
      check("R7 bpr_clr idle", {31'd0, bpr_clr}, 32'd0);

      // single-bit release sweep, each after a button reset
      for (int i = 0; i < 13; i++) begin
         press_button();
         check("R1 button reset state", {19'd0, state()}, {19'd0, ALL});
         wr({1'b0, 13'(1) << i});
         if (i == 0) tag = "R7";
         else if (i == 1) tag = "R3";
         else if (i == 2) tag = "R4";
         else if (i == 3 || i == 4) tag = "R5";
         else if (i == 5) tag = "R9";
         else tag = "R6";
         check(tag, {19'd0, state()}, {19'd0, ALL & ~(13'(1) << i)});
         wr(14'h0);
         check("R11 zero write", {19'd0, state()}, {19'd0, ALL & ~(13'(1) << i)});
      end

      // pattern sweep with periodic software resets
      press_button();
      exp = ALL;
      lfsr = 13'h0001;
      for (int p = 0; p < 48; p++) begin
         lfsr = {lfsr[11:0], lfsr[12] ^ lfsr[3] ^ lfsr[2] ^ lfsr[0]};
         wr({1'b0, lfsr});
         exp = exp & ~lfsr;
         check("R6 pattern release", {19'd0, state()}, {19'd0, exp});
         if (p % 8 == 7) begin
            sw_reset(hi, lo);
            check("R8 pulse length", hi, 16);
            check("R2 cpu untouched by sw", lo, 0);
            exp = exp | SWST;
            check("R9 R10 after sw reset", {19'd0, state()}, {19'd0, exp});
         end
      end

      // explicit time-out mask retention across software reset
      press_button();
      wr(14'h0020);
      sw_reset(hi, lo);
      check("R9 tmo kept by sw", {31'd0, tmo_mask}, 32'd0);
      check("R3 dram mask set by sw", {31'd0, dram_err_mask}, 32'd1);

      // hardware reset landing inside a software pulse
      wr(14'h1FFF);
      check("R11 full release", {19'd0, state()}, 32'd0);
      wr(14'h2000);
      repeat (4) @(negedge clk);
      btn_n = 1'b0;
      @(negedge clk);
      check("R2 button in sw pulse", {31'd0, cpu_rst_n}, 32'd0);
      check("R9 tmo set by hw", {31'd0, tmo_mask}, 32'd1);
      btn_n = 1'b1;
      for (int k = 0; k < 40 && !cpu_rst_n; k++) @(negedge clk);
      repeat (20) @(negedge clk);
      check("R1 state after overlap", {19'd0, state()}, {19'd0, ALL});
      check("R7 bpr idle after overlap", {31'd0, bpr_clr}, 32'd0);

      finish_run();
   end
endmodule